// File: doc/BRIEF.md
# Stall-Only Read-After-Write Hazard Detector

This block sits beside the decode stage of a five-stage in-order pipeline. Every cycle it takes the two register indices that the decode instruction may read. Each index comes with a flag that says whether it is actually read. The block compares them with the destination index and write enable held in each of the three pipeline registers after decode: decode/execute, execute/memory and memory/writeback. The register file is read in decode and written only in writeback, so a producer can still be any of those three stages ahead of its consumer.

Any live match makes the block stall the front of the pipeline at once, in the same cycle. The fetch address holds, the fetch/decode register holds, and a bubble goes into decode/execute in place of the decode instruction. The stall drops in the first cycle with no match. No result is bypassed: every dependency waits until its producer has left writeback. A producer directly followed by its consumer therefore costs three cycles, and each extra instruction of distance between them removes one cycle.

Top module: `hz_stall_detect`

## Requirements
- R1: With source A flagged as read and nonzero, a stall is raised when its index equals the destination of any one of decode/execute, execute/memory or memory/writeback whose write enable is 1. A different index raises none.
- R2: Source B is compared with the same three destinations in the same way, and the stall is the OR of the source A and source B results.
- R3: Register index 0 never causes a stall, on either source, even when a writing stage names index 0.
- R4: A source whose read flag is 0 never causes a stall, whatever its index. A store's data register is a source like any other.
- R5: A downstream stage whose write enable is 0 never causes a stall, whatever its destination index. This covers stores and nops.
- R6: pc_hold, ifid_hold and idex_bubble are combinational and always equal. All three are 1 in a cycle with a live match and 0 in a cycle without one, including the empty pipeline after reset.
- R7: In a closed pipeline loop, a consumer placed d instructions after its producer stalls 3 cycles at d=1, 2 at d=2, 1 at d=3 and 0 for d≥4. Every instruction leaves writeback exactly once, in program order.
- R8: A producer followed by four back-to-back consumers of its destination costs 3 stall cycles in total. All of them are spent on the first consumer, and the other three do not stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_idx | input | 5 | First source register index of the decode instruction |
| src_a_used | input | 1 | 1 when the decode instruction reads the first source |
| src_b_idx | input | 5 | Second source register index of the decode instruction |
| src_b_used | input | 1 | 1 when the decode instruction reads the second source |
| idex_dst | input | 5 | Destination index held in decode/execute |
| idex_we | input | 1 | Register write enable held in decode/execute |
| exmem_dst | input | 5 | Destination index held in execute/memory |
| exmem_we | input | 1 | Register write enable held in execute/memory |
| memwb_dst | input | 5 | Destination index held in memory/writeback |
| memwb_we | input | 1 | Register write enable held in memory/writeback |
| pc_hold | output | 1 | Keep the fetch address this cycle |
| ifid_hold | output | 1 | Keep the fetch/decode register this cycle |
| idex_bubble | output | 1 | Load a nop into decode/execute this cycle |

## Verification
The block is first driven open loop. A single matching destination is placed in each downstream stage in turn, for each source. This shows that all three distances are covered and that both sources feed the stall. Matches are then masked one at a time, by index zero, by a cleared read flag and by a cleared write enable, to tell each qualifier apart from the plain index compare. The bench then closes the loop around a small pipeline model and runs short programs: dependent pairs at distances one to five, a store as consumer, a store as producer and a producer with four consumers. The stall-cycle totals and the retirement order separate a correct release point from one that is a cycle early or a cycle late.

// File: rtl/hz_pkg.sv
package hz_pkg;

    // Architectural register file size and derived index width
    localparam int unsigned HZ_REG_COUNT = 32;
    localparam int unsigned HZ_IDX_W     = $clog2(HZ_REG_COUNT);

    // Downstream stages that may still hold an unwritten result
    localparam int unsigned HZ_STAGES    = 3;
    // Register sources per decode instruction
    localparam int unsigned HZ_SRCS      = 2;

    typedef logic [HZ_IDX_W-1:0] reg_idx_t;

    // Destination carried by a downstream pipeline register
    typedef struct packed {
        logic     wr;
        reg_idx_t idx;
    } dst_t;

    // Source requested by the decode instruction
    typedef struct packed {
        logic     rd;
        reg_idx_t idx;
    } src_t;

    // Front-end stall controls
    typedef struct packed {
        logic pc_hold;
        logic ifid_hold;
        logic idex_bubble;
    } stall_ctl_t;

    localparam stall_ctl_t STALL_NONE = '0;
    localparam stall_ctl_t STALL_ALL  = '1;

    // A source only matters when it is read and is not the hardwired zero
    function automatic logic src_live(src_t s);
        return s.rd && (s.idx != '0);
    endfunction

    // A destination only matters when the stage really writes a register
    function automatic logic dst_live(dst_t d);
        return d.wr && (d.idx != '0);
    endfunction

    function automatic logic raw_conflict(src_t s, dst_t d);
        return src_live(s) && dst_live(d) && (s.idx == d.idx);
    endfunction

endpackage

// File: rtl/hz_src_match.sv
module hz_src_match
    import hz_pkg::*;
#(
    parameter int unsigned N_STAGES = HZ_STAGES
) (
    input  src_t src,
    input  dst_t dsts [N_STAGES],
    output logic hit
);

    logic [N_STAGES-1:0] stage_hit;

    for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
        assign stage_hit[g] = raw_conflict(src, dsts[g]);

        // A matched stage must be one that writes
        always_comb begin
            if (stage_hit[g]) begin
                assert_stage_writes_R5: assert (dsts[g].wr)
                    else $error("stage %0d matched without write enable", g);
            end
        end
    end

    assign hit = |stage_hit;

    always_comb begin
        if (hit) begin
            assert_src_nonzero_R3: assert (src.idx != '0)
                else $error("register zero produced a hazard");
            assert_src_read_R4: assert (src.rd)
                else $error("unread source produced a hazard");
        end
    end

endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl
    import hz_pkg::*;
#(
    parameter int unsigned N_SRCS = HZ_SRCS
) (
    input  logic [N_SRCS-1:0] src_hit,
    output stall_ctl_t        ctl
);

    assign ctl = (|src_hit) ? STALL_ALL : STALL_NONE;

    always_comb begin
        assert_ctl_uniform_R6: assert (ctl == STALL_NONE || ctl == STALL_ALL)
            else $error("stall controls disagree");
    end

endmodule

// File: rtl/hz_stall_detect.sv
module hz_stall_detect
    import hz_pkg::*;
(
    input  logic [HZ_IDX_W-1:0] src_a_idx,
    input  logic                src_a_used,
    input  logic [HZ_IDX_W-1:0] src_b_idx,
    input  logic                src_b_used,
    input  logic [HZ_IDX_W-1:0] idex_dst,
    input  logic                idex_we,
    input  logic [HZ_IDX_W-1:0] exmem_dst,
    input  logic                exmem_we,
    input  logic [HZ_IDX_W-1:0] memwb_dst,
    input  logic                memwb_we,
    output logic                pc_hold,
    output logic                ifid_hold,
    output logic                idex_bubble
);

    src_t              srcs      [HZ_SRCS];
    dst_t              stage_dst [HZ_STAGES];
    logic [HZ_SRCS-1:0] src_hit;
    stall_ctl_t        ctl;

    // Youngest to oldest downstream stage
    assign stage_dst[0] = '{wr: idex_we,  idx: idex_dst};
    assign stage_dst[1] = '{wr: exmem_we, idx: exmem_dst};
    assign stage_dst[2] = '{wr: memwb_we, idx: memwb_dst};

    assign srcs[0] = '{rd: src_a_used, idx: src_a_idx};
    assign srcs[1] = '{rd: src_b_used, idx: src_b_idx};

    for (genvar s = 0; s < HZ_SRCS; s++) begin : g_src
        hz_src_match #(
            .N_STAGES (HZ_STAGES)
        ) u_match (
            .src  (srcs[s]),
            .dsts (stage_dst),
            .hit  (src_hit[s])
        );
    end

    hz_stall_ctrl #(
        .N_SRCS (HZ_SRCS)
    ) u_ctrl (
        .src_hit (src_hit),
        .ctl     (ctl)
    );

    assign pc_hold     = ctl.pc_hold;
    assign ifid_hold   = ctl.ifid_hold;
    assign idex_bubble = ctl.idex_bubble;

    // Port-level cross checks against the per-source compare units
    for (genvar g = 0; g < HZ_STAGES; g++) begin : g_chk
        always_comb begin
            if (src_a_used && src_a_idx != '0 && stage_dst[g].wr &&
                stage_dst[g].idx == src_a_idx) begin
                assert_srca_stage_R1: assert (pc_hold)
                    else $error("source A match in stage %0d not stalled", g);
            end
            if (src_b_used && src_b_idx != '0 && stage_dst[g].wr &&
                stage_dst[g].idx == src_b_idx) begin
                assert_srcb_stage_R2: assert (pc_hold)
                    else $error("source B match in stage %0d not stalled", g);
            end
        end
    end

    always_comb begin
        if (!idex_we && !exmem_we && !memwb_we) begin
            assert_no_writer_R5: assert (!pc_hold && !idex_bubble)
                else $error("stall with no writing stage");
        end
        if (!src_a_used && !src_b_used) begin
            assert_no_reader_R4: assert (!ifid_hold)
                else $error("stall with no source read");
        end
    end

endmodule

// File: tb/hz_stall_detect_tb.sv
`timescale 1ns/1ps
module hz_stall_detect_tb;
    import hz_pkg::*;

    localparam time HALF = 10ns;

    logic clk = 1'b0;
    always #HALF clk = ~clk;

    logic [HZ_IDX_W-1:0] src_a_idx, src_b_idx, idex_dst, exmem_dst, memwb_dst;
    logic src_a_used, src_b_used, idex_we, exmem_we, memwb_we;
    logic pc_hold, ifid_hold, idex_bubble;

    hz_stall_detect u_dut (
        .src_a_idx   (src_a_idx),
        .src_a_used  (src_a_used),
        .src_b_idx   (src_b_idx),
        .src_b_used  (src_b_used),
        .idex_dst    (idex_dst),
        .idex_we     (idex_we),
        .exmem_dst   (exmem_dst),
        .exmem_we    (exmem_we),
        .memwb_dst   (memwb_dst),
        .memwb_we    (memwb_we),
        .pc_hold     (pc_hold),
        .ifid_hold   (ifid_hold),
        .idex_bubble (idex_bubble)
    );

    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // ---------------- open-loop helpers ----------------
    task automatic drive(int a, bit ua, int b, bit ub,
                         int d0, bit w0, int d1, bit w1, int d2, bit w2);
        @(negedge clk);
        src_a_idx = a[HZ_IDX_W-1:0]; src_a_used = ua;
        src_b_idx = b[HZ_IDX_W-1:0]; src_b_used = ub;
        idex_dst  = d0[HZ_IDX_W-1:0]; idex_we  = w0;
        exmem_dst = d1[HZ_IDX_W-1:0]; exmem_we = w1;
        memwb_dst = d2[HZ_IDX_W-1:0]; memwb_we = w2;
        #1;
    endtask

    // All three controls must equal exp (R6 encoding: 3'b111 or 3'b000)
    task automatic expect_stall(string req, bit exp);
        chk(req, int'({pc_hold, ifid_hold, idex_bubble}), exp ? 7 : 0);
    endtask

    task automatic t_reset_state();
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        expect_stall("R6 empty pipeline", 1'b0);
    endtask

    task automatic t_src_a_stages();
        drive(5, 1, 9, 1, 5, 1, 0, 0, 0, 0); expect_stall("R1 A vs ID/EX", 1'b1);
        drive(5, 1, 9, 1, 0, 0, 5, 1, 0, 0); expect_stall("R1 A vs EX/MEM", 1'b1);
        drive(5, 1, 9, 1, 0, 0, 0, 0, 5, 1); expect_stall("R1 A vs MEM/WB", 1'b1);
        drive(5, 1, 9, 1, 6, 1, 7, 1, 4, 1); expect_stall("R1 A no match", 1'b0);
    endtask

    task automatic t_src_b_stages();
        drive(9, 1, 12, 1, 12, 1, 0, 0, 0, 0); expect_stall("R2 B vs ID/EX", 1'b1);
        drive(9, 1, 12, 1, 0, 0, 12, 1, 0, 0); expect_stall("R2 B vs EX/MEM", 1'b1);
        drive(9, 1, 12, 1, 0, 0, 0, 0, 12, 1); expect_stall("R2 B vs MEM/WB", 1'b1);
        drive(9, 1, 12, 1, 9, 1, 12, 1, 0, 0); expect_stall("R2 A and B both", 1'b1);
    endtask

    task automatic t_zero_reg();
        drive(0, 1, 0, 1, 0, 1, 0, 1, 0, 1); expect_stall("R3 r0 both sources", 1'b0);
        drive(0, 1, 3, 1, 0, 1, 0, 1, 0, 1); expect_stall("R3 r0 on A, B free", 1'b0);
    endtask

    task automatic t_use_flags();
        drive(7, 0, 8, 0, 7, 1, 8, 1, 7, 1); expect_stall("R4 both unread", 1'b0);
        drive(7, 0, 8, 1, 7, 1, 0, 0, 8, 1); expect_stall("R4 B read only", 1'b1);
    endtask

    task automatic t_write_enables();
        drive(11, 1, 11, 1, 11, 0, 11, 0, 11, 0); expect_stall("R5 no writers", 1'b0);
        drive(11, 1, 2, 1, 11, 0, 11, 0, 11, 1);  expect_stall("R5 only MEM/WB writes", 1'b1);
    endtask

    // ---------------- closed-loop pipeline model ----------------
    typedef struct {
        int id;
        bit wr; int dst;
        bit ra; int a;
        bit rb; int b;
    } ins_t;

    localparam int PMAX = 16;
    ins_t prog [PMAX];
    int   plen;

    function automatic ins_t mk(int id, bit wr, int dst, bit ra, int a, bit rb, int b);
        ins_t r;
        r.id = id; r.wr = wr; r.dst = dst; r.ra = ra; r.a = a; r.rb = rb; r.b = b;
        return r;
    endfunction

    function automatic ins_t bubble();
        return mk(-1, 0, 0, 0, 0, 0, 0);
    endfunction

    // Runs prog, returns stall cycles, retired count, order flag and stall
    // cycles spent while instruction first_id sat in decode.
    task automatic run_prog(output int stalls, output int retired,
                            output bit in_order, input int focus_id,
                            output int focus_stalls);
        ins_t ifid, idex, exmem, memwb;
        int   pc;
        bit   st;
        ifid = bubble(); idex = bubble(); exmem = bubble(); memwb = bubble();
        pc = 0; stalls = 0; retired = 0; in_order = 1; focus_stalls = 0;
        for (int c = 0; c < 80 && retired < plen; c++) begin
            @(negedge clk);
            src_a_idx = ifid.a[HZ_IDX_W-1:0];   src_a_used = ifid.ra;
            src_b_idx = ifid.b[HZ_IDX_W-1:0];   src_b_used = ifid.rb;
            idex_dst  = idex.dst[HZ_IDX_W-1:0];  idex_we  = idex.wr;
            exmem_dst = exmem.dst[HZ_IDX_W-1:0]; exmem_we = exmem.wr;
            memwb_dst = memwb.dst[HZ_IDX_W-1:0]; memwb_we = memwb.wr;
            #1;
            st = pc_hold;
            if (st != ifid_hold || st != idex_bubble) in_order = 0;
            if (st) begin
                stalls++;
                if (ifid.id == focus_id) focus_stalls++;
            end
            @(posedge clk);
            if (memwb.id >= 0) begin
                if (memwb.id != retired) in_order = 0;
                retired++;
            end
            memwb = exmem;
            exmem = idex;
            if (st) begin
                idex = bubble();
            end else begin
                idex = ifid;
                if (pc < plen) begin ifid = prog[pc]; pc++; end
                else ifid = bubble();
            end
        end
    endtask

    // Producer writes r5, d-1 independent fillers, consumer reads r5
    task automatic t_distance_pair(int d, bit on_b, bit cons_writes, int exp);
        int st, ret, foc; bit ord;
        string tag;
        plen = 0;
        prog[plen] = mk(plen, 1, 5, 0, 0, 0, 0); plen++;
        for (int k = 1; k < d; k++) begin
            prog[plen] = mk(plen, 1, 20 + k, 0, 0, 0, 0); plen++;
        end
        prog[plen] = on_b ? mk(plen, cons_writes, cons_writes ? 6 : 0, 1, 2, 1, 5)
                          : mk(plen, cons_writes, cons_writes ? 6 : 0, 1, 5, 0, 0);
        plen++;
        run_prog(st, ret, ord, -2, foc);
        tag = $sformatf("R7 distance %0d%s stalls", d, on_b ? " (B/store)" : "");
        chk(tag, st, exp);
        chk("R7 all retired once", ret, plen);
        chk("R7 retire order", int'(ord), 1);
    endtask

    task automatic t_distances();
        t_distance_pair(1, 0, 1, 3);
        t_distance_pair(2, 0, 1, 2);
        t_distance_pair(3, 0, 1, 1);
        t_distance_pair(4, 0, 1, 0);
        t_distance_pair(5, 0, 1, 0);
        t_distance_pair(1, 1, 0, 3);   // store-like consumer reading data on B
    endtask

    // Store (no write) producing index 5, then a reader of r5: R5
    task automatic t_store_producer();
        int st, ret, foc; bit ord;
        plen = 2;
        prog[0] = mk(0, 0, 5, 1, 1, 1, 5);
        prog[1] = mk(1, 1, 6, 1, 5, 0, 0);
        run_prog(st, ret, ord, -2, foc);
        chk("R5 store producer stalls", st, 0);
        chk("R5 store producer retired", ret, 2);
    endtask

    task automatic t_four_consumers();
        int st, ret, foc; bit ord;
        plen = 5;
        prog[0] = mk(0, 1, 3, 0, 0, 0, 0);
        for (int k = 1; k <= 4; k++) prog[k] = mk(k, 1, 5 + k, 1, 3, 0, 0);
        run_prog(st, ret, ord, 1, foc);
        chk("R8 total stalls", st, 3);
        chk("R8 stalls on first consumer", foc, 3);
        chk("R8 retired", ret, 5);
        chk("R8 order", int'(ord), 1);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(2 * HALF * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R7: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        src_a_idx = '0; src_a_used = 0; src_b_idx = '0; src_b_used = 0;
        idex_dst = '0; idex_we = 0; exmem_dst = '0; exmem_we = 0;
        memwb_dst = '0; memwb_we = 0;
        repeat (3) @(posedge clk);
        t_reset_state();
        t_src_a_stages();
        t_src_b_stages();
        t_zero_reg();
        t_use_flags();
        t_write_enables();
        t_distances();
        t_store_producer();
        t_four_consumers();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule